// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches two edge signals: the reference path and the feedback path that feed a phase-frequency detector. Both pass through two-flop synchronizers into a fast sampling clock domain. There, each rising edge on one path is paired with the next rising edge on the other path, and the gap between the two is counted in sampling-clock ticks. Each completed pair is one PFD cycle.

A PFD cycle counts as in-window when its gap is below a lock window. The block raises `lockFlag` after a selectable run of consecutive in-window cycles. Once the flag is set, it stays set through moderate phase error. It falls only when a gap exceeds a wider loss-of-lock threshold. Software selects the run length, a wide or narrow threshold pair, and a disable bit. If the partner edge does not arrive within a timeout, that cycle is treated as a gross phase error.

Top module: `pfd_lock_monitor`

## Requirements
- R1: After the synchronous active-low reset, `lockFlag` is 0 and the consecutive count is zero.
- R2: `runSel` selects how many consecutive in-window cycles set the flag: 00 means 5, 01 means 16, 10 means 64 and 11 means 255. The flag stays low after one cycle fewer than the selected number and rises on the last one.
- R3: A cycle is in-window only when its gap in ticks is strictly less than the window. A gap equal to the window does not count.
- R4: While locked, any gap up to and including the loss-of-lock threshold keeps the flag set. A gap greater than that threshold clears the flag and the count.
- R5: `narrowRange`=0 selects the wide pair (window 8, loss 16 ticks by default). `narrowRange`=1 selects the narrow pair (window 3, loss 6 ticks by default).
- R6: Before lock, any cycle that is not in-window returns the consecutive count to zero.
- R7: While `detectOff`=1, the flag is held low and the count is held at zero. After the bit is cleared, a full new run is needed.
- R8: When a leading edge gets no partner within TIMEOUT ticks (63 by default), that cycle counts as beyond the loss threshold. The same holds when the same path repeats its edge first.
- R9: Either path may lead. The gap is measured the same way whether the reference edge or the feedback edge comes first, and simultaneous edges give a gap of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Synchronous active-low reset |
| refIn | input | 1 | Reference-path edge signal, asynchronous |
| fbIn | input | 1 | Feedback-path edge signal, asynchronous |
| runSel | input | 2 | Consecutive-cycle run length select |
| narrowRange | input | 1 | 0 selects the wide thresholds, 1 selects the narrow thresholds |
| detectOff | input | 1 | 1 disables detection and holds the flag low |
| lockFlag | output | 1 | Lock indication |

## Verification
A wrong consecutive count appears at `lockFlag` as a rise one or more PFD cycles early or late. It therefore shows up on the first run that ends at the selected length. A wrong gap measurement or a wrong threshold compare shifts the boundary between counting and resetting by a tick. Gaps placed exactly on each window and loss value expose this within one cycle. Stale pairing state after a missing edge appears as a false lock or a missed loss on the very next pair. Each PFD cycle's result reaches the flag three sampling clocks after the later edge.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  localparam int RUN_W = 8;

  // per-PFD-cycle result handed from the gap datapath to the lock control
  typedef struct packed {
    logic valid;
    logic inWindow;
    logic beyondLoss;
  } gap_strobe_t;

  // R2: run length select decode
  function automatic logic [RUN_W-1:0] runTarget(input logic [1:0] sel);
    case (sel)
      2'b00:   return RUN_W'(5);
      2'b01:   return RUN_W'(16);
      2'b10:   return RUN_W'(64);
      default: return RUN_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/pfd_gap_datapath.sv
module pfd_gap_datapath
  import pfd_lock_pkg::*;
#(
  parameter int WIN_WIDE    = 8,
  parameter int LOSS_WIDE   = 16,
  parameter int WIN_NARROW  = 3,
  parameter int LOSS_NARROW = 6,
  parameter int TIMEOUT     = 63
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refIn,
  input  logic        fbIn,
  input  logic        narrowRange,
  output gap_strobe_t strobes
);
  localparam int GW = $clog2(TIMEOUT + 1);
  localparam logic [GW-1:0] TIMEOUT_V = GW'(TIMEOUT);
  localparam logic [GW-1:0] WIN_W_V   = GW'(WIN_WIDE);
  localparam logic [GW-1:0] LOSS_W_V  = GW'(LOSS_WIDE);
  localparam logic [GW-1:0] WIN_N_V   = GW'(WIN_NARROW);
  localparam logic [GW-1:0] LOSS_N_V  = GW'(LOSS_NARROW);

  typedef enum logic [1:0] {PAIR_IDLE, PAIR_WAIT_FB, PAIR_WAIT_REF} pair_state_t;

  logic [1:0] rawIn;
  logic [1:0] stage1, stage2, stage3;
  logic [1:0] edgeHit;
  assign rawIn = {fbIn, refIn};

  // two-flop synchronizer plus edge-detect delay, per input
  for (genvar g = 0; g < 2; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1[g] <= 1'b0;
        stage2[g] <= 1'b0;
        stage3[g] <= 1'b0;
      end else begin
        stage1[g] <= rawIn[g];
        stage2[g] <= stage1[g];
        stage3[g] <= stage2[g];
      end
    end
    assign edgeHit[g] = stage2[g] & ~stage3[g];
  end

  logic refEdge, fbEdge;
  assign refEdge = edgeHit[0];
  assign fbEdge  = edgeHit[1];

  pair_state_t state, nextState;
  logic [GW-1:0] gapCnt, nextCnt, gapVal;
  logic sampleValid, leaderEdge, followerEdge;

  assign leaderEdge   = (state == PAIR_WAIT_FB) ? refEdge : fbEdge;
  assign followerEdge = (state == PAIR_WAIT_FB) ? fbEdge  : refEdge;

  always_comb begin
    nextState   = state;
    nextCnt     = gapCnt;
    sampleValid = 1'b0;
    gapVal      = '0;
    if (state == PAIR_IDLE) begin
      if (refEdge && fbEdge) begin
        sampleValid = 1'b1;
      end else if (refEdge) begin
        nextState = PAIR_WAIT_FB;
        nextCnt   = GW'(1);
      end else if (fbEdge) begin
        nextState = PAIR_WAIT_REF;
        nextCnt   = GW'(1);
      end
    end else begin
      if (followerEdge) begin
        sampleValid = 1'b1;
        gapVal      = gapCnt;
        nextState   = PAIR_IDLE;
      end else if (leaderEdge || gapCnt == TIMEOUT_V) begin
        sampleValid = 1'b1;
        gapVal      = TIMEOUT_V;
        nextState   = PAIR_IDLE;
      end else begin
        nextCnt = gapCnt + GW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PAIR_IDLE;
      gapCnt <= '0;
    end else begin
      state  <= nextState;
      gapCnt <= nextCnt;
    end
  end

  logic [GW-1:0] winSel, lossSel;
  assign winSel  = narrowRange ? WIN_N_V  : WIN_W_V;
  assign lossSel = narrowRange ? LOSS_N_V : LOSS_W_V;

  assign strobes.valid      = sampleValid;
  assign strobes.inWindow   = sampleValid && (gapVal < winSel);
  assign strobes.beyondLoss = sampleValid && (gapVal > lossSel);

  // R8: a pending measurement never runs past the timeout
  p_gap_bounded_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != PAIR_IDLE) |-> (gapCnt >= GW'(1) && gapCnt <= TIMEOUT_V));

  // R8: a timed-out pairing is reported as a gross phase error
  p_miss_is_loss_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != PAIR_IDLE && gapCnt == TIMEOUT_V && !followerEdge) |-> strobes.beyondLoss);

  // R4: the window always lies inside the loss threshold
  p_window_inside_loss_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inWindow |-> !strobes.beyondLoss);
endmodule

// File: rtl/pfd_lock_control.sv
module pfd_lock_control
  import pfd_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  gap_strobe_t strobes,
  input  logic [1:0]  runSel,
  input  logic        detectOff,
  output logic        lockFlag
);
  logic [RUN_W-1:0] runCnt, target;
  logic [RUN_W:0]   runNext;

  assign target  = runTarget(runSel);
  assign runNext = {1'b0, runCnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || detectOff) begin
      lockFlag <= 1'b0;
      runCnt   <= '0;
    end else if (strobes.valid) begin
      if (lockFlag) begin
        if (strobes.beyondLoss) begin
          lockFlag <= 1'b0;
          runCnt   <= '0;
        end
      end else if (strobes.inWindow) begin
        if (runNext >= {1'b0, target}) begin
          lockFlag <= 1'b1;
          runCnt   <= target;
        end else begin
          runCnt <= runNext[RUN_W-1:0];
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // R2: lock only ever rises on an in-window cycle
  p_rise_on_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(strobes.valid && strobes.inWindow));

  // R4: lock only ever falls on loss or disable
  p_fall_on_loss_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockFlag) |-> $past(detectOff || strobes.beyondLoss));

  // R7: disable forces the flag low and empties the count
  p_off_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    detectOff |=> (!lockFlag && runCnt == '0));

  // R6: a non-window cycle before lock empties the count
  p_reset_on_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!detectOff && !lockFlag && strobes.valid && !strobes.inWindow) |=> runCnt == '0);
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor #(
  parameter int WIN_WIDE    = 8,
  parameter int LOSS_WIDE   = 16,
  parameter int WIN_NARROW  = 3,
  parameter int LOSS_NARROW = 6,
  parameter int TIMEOUT     = 63
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       fbIn,
  input  logic [1:0] runSel,
  input  logic       narrowRange,
  input  logic       detectOff,
  output logic       lockFlag
);
  pfd_lock_pkg::gap_strobe_t strobes;

  pfd_gap_datapath #(
    .WIN_WIDE(WIN_WIDE), .LOSS_WIDE(LOSS_WIDE),
    .WIN_NARROW(WIN_NARROW), .LOSS_NARROW(LOSS_NARROW),
    .TIMEOUT(TIMEOUT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn),
    .narrowRange(narrowRange), .strobes(strobes)
  );

  pfd_lock_control i_control (
    .clk(clk), .rstN(rstN), .strobes(strobes), .runSel(runSel),
    .detectOff(detectOff), .lockFlag(lockFlag)
  );
endmodule

// File: tb/test_pfd_lock_monitor.sv
`timescale 1ns/1ps
module test_pfd_lock_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0, fbIn = 1'b0;
  logic [1:0] runSel = 2'b00;
  logic narrowRange = 1'b0, detectOff = 1'b0;
  logic lockFlag;

  int tests = 0, fails = 0;
  int mCnt = 0;
  bit mFlag = 1'b0;

  always #2 clk = ~clk;

  pfd_lock_monitor i_pfd_lock_monitor (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn), .runSel(runSel),
    .narrowRange(narrowRange), .detectOff(detectOff), .lockFlag(lockFlag)
  );

  function automatic int winOf(bit narrow);
    return narrow ? 3 : 8;
  endfunction
  function automatic int lossOf(bit narrow);
    return narrow ? 6 : 16;
  endfunction
  function automatic int targetOf(logic [1:0] sel);
    case (sel)
      2'b00: return 5;
      2'b01: return 16;
      2'b10: return 64;
      default: return 255;
    endcase
  endfunction

  task automatic modelGap(int gap);
    if (detectOff) begin mFlag = 0; mCnt = 0; return; end
    if (mFlag) begin
      if (gap > lossOf(narrowRange)) begin mFlag = 0; mCnt = 0; end
    end else if (gap < winOf(narrowRange)) begin
      mCnt++;
      if (mCnt >= targetOf(runSel)) begin mFlag = 1; mCnt = targetOf(runSel); end
    end else mCnt = 0;
  endtask

  task automatic check(bit exp, string req);
    tests++;
    if (lockFlag !== exp) begin
      fails++;
      $display("FAIL %s: lockFlag=%0b expected %0b at %0t", req, lockFlag, exp, $time);
    end
  endtask

  // one PFD cycle with a gap of 'gap' ticks; fbLead swaps which path is first
  task automatic pair(int gap, bit fbLead);
    @(negedge clk);
    if (gap == 0) begin refIn = 1; fbIn = 1; end
    else if (fbLead) fbIn = 1; else refIn = 1;
    repeat (gap) @(negedge clk);
    refIn = 1; fbIn = 1;
    repeat (2) @(negedge clk);
    refIn = 0; fbIn = 0;
    repeat (4) @(negedge clk);
    modelGap(gap);
  endtask

  task automatic missing();
    @(negedge clk);
    refIn = 1;
    repeat (2) @(negedge clk);
    refIn = 0;
    repeat (75) @(negedge clk);
    modelGap(1000);
  endtask

  task automatic runTo(int n, int gap, string req);
    for (int i = 0; i < n - 1; i++) pair(gap, i[0]);
    check(1'b0, req);
    pair(gap, 1'b0);
    check(1'b1, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(1'b0, "R1 in reset");
    rstN = 1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 after reset");

    // R2 default run of 5, wide window
    runTo(5, 4, "R2 run 5");

    // R4 hysteresis on the wide pair
    pair(12, 0); check(1'b1, "R4 gap 12 holds");
    pair(16, 1); check(1'b1, "R4 gap 16 holds");
    pair(8, 0);  check(1'b1, "R4 gap 8 holds");
    pair(17, 0); check(1'b0, "R4 gap 17 drops");

    // R3 and R6: gap equal to window breaks the run
    for (int i = 0; i < 4; i++) pair(7, 0);
    check(1'b0, "R3 four at 7");
    pair(8, 0); check(1'b0, "R3 gap 8 not in window");
    for (int i = 0; i < 4; i++) pair(7, 1);
    check(1'b0, "R6 count restarted");
    pair(7, 0); check(1'b1, "R6 lock after fresh run");

    // R5 narrow pair
    pair(17, 0); check(1'b0, "R5 unlock");
    narrowRange = 1;
    for (int i = 0; i < 4; i++) pair(2, 0);
    pair(3, 0); check(1'b0, "R5 narrow gap 3 outside");
    runTo(5, 2, "R5 narrow lock");
    pair(6, 1); check(1'b1, "R5 narrow gap 6 holds");
    pair(7, 1); check(1'b0, "R5 narrow gap 7 drops");
    narrowRange = 0;

    // R9 feedback leading, and simultaneous edges
    for (int i = 0; i < 4; i++) pair(5, 1);
    pair(0, 0); check(1'b1, "R9 fb lead and zero gap");

    // R7 disable
    @(negedge clk); detectOff = 1;
    repeat (2) @(negedge clk);
    modelGap(0);
    check(1'b0, "R7 forced low");
    pair(1, 0); check(1'b0, "R7 ignores pairs");
    detectOff = 0;
    pair(1, 0); check(1'b0, "R7 fresh run needed");
    for (int i = 0; i < 3; i++) pair(1, 0);
    pair(1, 0); check(1'b1, "R7 relock");

    // R8 missing partner edge
    missing(); check(1'b0, "R8 timeout drops");

    // R2 longer runs
    runSel = 2'b01; runTo(16, 0, "R2 run 16");
    pair(20, 0); check(1'b0, "R2 unlock");
    runSel = 2'b10; runTo(64, 1, "R2 run 64");
    pair(20, 1); check(1'b0, "R2 unlock");
    runSel = 2'b11; runTo(255, 3, "R2 run 255");
    pair(20, 0); check(1'b0, "R2 unlock");

    // constrained random mix
    runSel = 2'b00;
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) narrowRange = $urandom_range(1, 0);
      if (i % 101 == 50) runSel = 2'b01;
      if (i % 101 == 0) runSel = 2'b00;
      if ($urandom_range(9, 0) < 7)
        pair($urandom_range(narrowRange ? 4 : 9, 0), $urandom_range(1, 0));
      else
        pair($urandom_range(20, 0), $urandom_range(1, 0));
      check(mFlag, "R4 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule